// File: doc/BRIEF.md
# Remote Boot Authentication Handshake Sequencer

This block is the host-side controller that takes a remote processor from reset to an authenticated image. It talks to the remote side only through a small mailbox register window, using one single-word write or read per cycle. A start pulse launches the sequence. The block posts the boot image address and polls the first-stage boot status. It then polls the loader status until the loader reports that it is running. Next it clears the code-length word, posts the metadata address and issues the metadata command, then waits for the metadata verdict. After that it takes segment descriptors from a valid/ready stream and announces each loadable segment by accumulating the code-length word. The load command goes out only for the first counted segment. Finally it waits for the remote side to report that authentication is complete.

Every wait has its own limit, counted in pulses of a 1 ms tick-enable input, and one status read is issued per tick. The result is held on three flags (`done`, `err`, `tmo`) plus a 3-bit code until the next start pulse. Copying memory and parsing images are left to other logic. The address inputs must stay constant while a run is in progress.

States: `S_IDLE`, `S_IMG_WR`, `S_POLL_RD`, `S_POLL_EVAL`, `S_POLL_WAIT`, `S_LEN_CLR`, `S_META_WR`, `S_META_CMD`, `S_SEG_WAIT`, `S_LEN_RD`, `S_LEN_EVAL`, `S_BASE_WR`, `S_LOAD_CMD`, `S_LEN_WR`, `S_DONE`, `S_FAIL`.

Transitions:
- Start: `S_IDLE`, `S_DONE` or `S_FAIL` on `start` go to `S_IMG_WR`.
- First poll: `S_IMG_WR` goes to `S_POLL_RD` in the primary stage.
- Poll loop: `S_POLL_RD` goes to `S_POLL_EVAL`. A pending verdict goes to `S_POLL_WAIT`. A tick there goes back to `S_POLL_RD`, or to `S_FAIL` on the last tick of the limit.
- Passes:
  - A primary pass goes to `S_POLL_RD` in the loader stage.
  - A loader pass goes through `S_LEN_CLR`, `S_META_WR` and `S_META_CMD` to `S_POLL_RD` in the metadata stage.
  - A metadata pass goes to `S_SEG_WAIT`.
  - A final pass goes to `S_DONE`.
- Bad status: a bad verdict goes to `S_FAIL`.
- Segment path: `S_SEG_WAIT` takes a descriptor.
  - A skipped descriptor stays in `S_SEG_WAIT`, or goes to the final poll if it is the last one.
  - A counted descriptor goes `S_LEN_RD`, then `S_LEN_EVAL`. A zero length goes through `S_BASE_WR` and `S_LOAD_CMD`. `S_LEN_WR` follows either way. After it the block returns to `S_SEG_WAIT`, or starts the final poll if the descriptor was the last one.

Top module: `boot_auth_seq`

## Requirements
- R1: After reset `done`, `err`, `tmo`, `mb_wr`, `mb_rd` and `seg_ready` are all 0 and stay 0 until `start`.
- R2: On `start` the first mailbox access writes `img_addr` to byte offset 0x00. The following accesses are reads of offset 0x04 (primary status).
- R3: In the primary stage, a read of 0 keeps polling, a read of 1 passes, and any other value fails with `err`=1 and `err_code`=3'b000.
- R4: In the loader stage (reads of offset 0x0C), 0 keeps polling, 1 and 2 both pass, and any other value, negative ones included, fails with `err_code`=3'b010.
- R5: After the loader passes, the block writes 0 to offset 0x18, then `meta_addr` to 0x10, then the value 1 to 0x08 (command word). It then polls 0x0C for the value 3.
- R6: In the metadata and final stages, a status with bit 31 set fails at once (`err_code` 3'b100 and 3'b110). A non-negative value other than the expected one (3, respectively 4) keeps polling.
- R7: For a counted segment the block reads offset 0x18. If the value read is 0, it writes `code_base` to 0x14 and then the value 2 to 0x08. In both cases it then writes the value read plus `seg_size` to 0x18.
- R8: A descriptor with `seg_loadable`=0, `seg_hash`=1 or `seg_size`=0 is accepted without any mailbox access.
- R9: Once the descriptor with `seg_last`=1 has been handled, the block polls 0x0C and raises `done` when it reads 4.
- R10: `err_code` bits [2:1] name the stage (0 primary, 1 loader, 2 metadata, 3 final) and bit 0 is 1 for a timeout. A stage with limit L ticks issues exactly L status reads and then raises `tmo`.
- R11: Status reads are spaced one per tick. A pass on the L-th read of a stage is accepted as a pass.
- R12: At most one of `done`, `err` and `tmo` is set. It holds until `start`. A `start` during a run is ignored, and a `start` from a finished run clears the flags in the next cycle and begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| tick_ms | input | 1 | 1 ms tick enable, one cycle wide, at least 3 cycles apart |
| img_addr | input | DW | Boot image address to publish |
| meta_addr | input | DW | Metadata buffer address |
| code_base | input | DW | Code start address |
| seg_valid | input | 1 | Segment descriptor valid |
| seg_ready | output | 1 | Segment descriptor accepted |
| seg_loadable | input | 1 | Segment is loadable |
| seg_hash | input | 1 | Segment is a hash segment |
| seg_size | input | DW | Segment memory size |
| seg_last | input | 1 | Final descriptor |
| mb_wr | output | 1 | Mailbox write strobe |
| mb_rd | output | 1 | Mailbox read strobe, data expected in the next cycle |
| mb_addr | output | 5 | Mailbox byte offset |
| mb_wdata | output | DW | Mailbox write data |
| mb_rdata | input | DW | Mailbox read data, valid the cycle after `mb_rd` |
| done | output | 1 | Authentication complete |
| err | output | 1 | Failed on a bad status |
| tmo | output | 1 | Failed on a timeout |
| err_code | output | 3 | Failing stage and kind |

## Verification
The hardest situation to reach is the edge of a stage limit: a pass arriving exactly on the L-th read must still count, while one more tick without a pass must time out. The bench's mailbox model returns zero for a programmed number of status reads before replying. Setting that number to L-1 for the primary stage, and to "never" for the loader stage, puts both edges in one run. The read counts for each stage are then compared against L. Skipped descriptors are interleaved between counted ones, so that the write log and the code-length read count show at the ports that the skipped ones caused no access.

// File: rtl/boot_auth_pkg.sv
package boot_auth_pkg;

    // Mailbox byte offsets, decoded by the remote side
    localparam logic [4:0] OFS_IMG   = 5'h00;
    localparam logic [4:0] OFS_PRI   = 5'h04;
    localparam logic [4:0] OFS_CMD   = 5'h08;
    localparam logic [4:0] OFS_LDR   = 5'h0C;
    localparam logic [4:0] OFS_META  = 5'h10;
    localparam logic [4:0] OFS_START = 5'h14;
    localparam logic [4:0] OFS_LEN   = 5'h18;

    localparam int CMD_META_RDY = 1;
    localparam int CMD_LOAD_RDY = 2;

    localparam int ST_PRI_OK    = 1;
    localparam int ST_UNLOCK    = 1;
    localparam int ST_UNLOCK_SC = 2;
    localparam int ST_META_OK   = 3;
    localparam int ST_AUTH_OK   = 4;

    typedef enum logic [1:0] {
        STG_PRI  = 2'd0,
        STG_LDR  = 2'd1,
        STG_META = 2'd2,
        STG_AUTH = 2'd3
    } stage_e;

    typedef enum logic [1:0] {
        VERD_WAIT = 2'd0,
        VERD_PASS = 2'd1,
        VERD_FAIL = 2'd2
    } verdict_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_IMG_WR,
        S_POLL_RD,
        S_POLL_EVAL,
        S_POLL_WAIT,
        S_LEN_CLR,
        S_META_WR,
        S_META_CMD,
        S_SEG_WAIT,
        S_LEN_RD,
        S_LEN_EVAL,
        S_BASE_WR,
        S_LOAD_CMD,
        S_LEN_WR,
        S_DONE,
        S_FAIL
    } state_e;

endpackage

// File: rtl/boot_auth_judge.sv
module boot_auth_judge
    import boot_auth_pkg::*;
#(
    parameter int DW = 32
) (
    input  stage_e          stage,
    input  logic [DW-1:0]   word,
    output verdict_e        verdict
);

    logic neg;
    assign neg = word[DW-1];

    always_comb begin
        verdict = VERD_WAIT;
        unique case (stage)
            STG_PRI: begin
                if (word == DW'(ST_PRI_OK))      verdict = VERD_PASS;
                else if (word != '0)             verdict = VERD_FAIL;
            end
            STG_LDR: begin
                if (word == DW'(ST_UNLOCK) || word == DW'(ST_UNLOCK_SC))
                                                 verdict = VERD_PASS;
                else if (word != '0)             verdict = VERD_FAIL;
            end
            STG_META: begin
                if (neg)                         verdict = VERD_FAIL;
                else if (word == DW'(ST_META_OK)) verdict = VERD_PASS;
            end
            STG_AUTH: begin
                if (neg)                         verdict = VERD_FAIL;
                else if (word == DW'(ST_AUTH_OK)) verdict = VERD_PASS;
            end
        endcase
    end

endmodule

// File: rtl/boot_auth_timer.sv
module boot_auth_timer #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          at_last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (step)   cnt_q <= cnt_q + 1'b1;
    end

    assign at_last = (cnt_q == limit - 1'b1);

    // elapsed ticks never reach the stage limit
    assert_cnt_below_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0) |-> (cnt_q < limit));

endmodule

// File: rtl/boot_auth_seg_filter.sv
module boot_auth_seg_filter #(
    parameter int DW = 32
) (
    input  logic          loadable,
    input  logic          hash,
    input  logic [DW-1:0] size,
    output logic          skip
);

    always_comb begin
        skip = 1'b0;
        if (!loadable)      skip = 1'b1;
        else if (hash)      skip = 1'b1;
        else if (size == '0) skip = 1'b1;
    end

endmodule

// File: rtl/boot_auth_seq.sv
module boot_auth_seq
    import boot_auth_pkg::*;
#(
    parameter int DW         = 32,
    parameter int PRI_LIMIT  = 1000,
    parameter int LDR_LIMIT  = 5000,
    parameter int META_LIMIT = 1000,
    parameter int AUTH_LIMIT = 10000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tick_ms,
    input  logic [DW-1:0] img_addr,
    input  logic [DW-1:0] meta_addr,
    input  logic [DW-1:0] code_base,
    input  logic          seg_valid,
    output logic          seg_ready,
    input  logic          seg_loadable,
    input  logic          seg_hash,
    input  logic [DW-1:0] seg_size,
    input  logic          seg_last,
    output logic          mb_wr,
    output logic          mb_rd,
    output logic [4:0]    mb_addr,
    output logic [DW-1:0] mb_wdata,
    input  logic [DW-1:0] mb_rdata,
    output logic          done,
    output logic          err,
    output logic          tmo,
    output logic [2:0]    err_code
);

    localparam int MAX_AB = (PRI_LIMIT > LDR_LIMIT) ? PRI_LIMIT : LDR_LIMIT;
    localparam int MAX_CD = (META_LIMIT > AUTH_LIMIT) ? META_LIMIT : AUTH_LIMIT;
    localparam int MAXL   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW     = $clog2(MAXL + 1);

    state_e   state_q, state_n;
    stage_e   stage_q, stage_n;
    verdict_e verdict;
    logic [DW-1:0] len_q, size_q;
    logic          last_q;
    logic          skip, at_last, tmr_clr, tmr_step;
    logic [CW-1:0] limit;
    logic          fail_tmo_n;
    logic          in_poll, idle_like;

    // ---------------- sub-blocks ----------------
    boot_auth_judge #(.DW(DW)) judge_i (
        .stage   (stage_q),
        .word    (mb_rdata),
        .verdict (verdict)
    );

    boot_auth_seg_filter #(.DW(DW)) filt_i (
        .loadable (seg_loadable),
        .hash     (seg_hash),
        .size     (seg_size),
        .skip     (skip)
    );

    always_comb begin
        unique case (stage_q)
            STG_PRI:  limit = CW'(PRI_LIMIT);
            STG_LDR:  limit = CW'(LDR_LIMIT);
            STG_META: limit = CW'(META_LIMIT);
            STG_AUTH: limit = CW'(AUTH_LIMIT);
        endcase
    end

    assign in_poll   = (state_q == S_POLL_RD) || (state_q == S_POLL_EVAL) ||
                       (state_q == S_POLL_WAIT);
    assign idle_like = (state_q == S_IDLE) || (state_q == S_DONE) ||
                       (state_q == S_FAIL);
    assign tmr_clr   = !in_poll || ((state_q == S_POLL_EVAL) && (verdict == VERD_PASS));
    assign tmr_step  = (state_q == S_POLL_WAIT) && tick_ms && !at_last;

    boot_auth_timer #(.CW(CW)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .step    (tmr_step),
        .limit   (limit),
        .at_last (at_last)
    );

    // ---------------- next state ----------------
    always_comb begin
        state_n    = state_q;
        stage_n    = stage_q;
        fail_tmo_n = 1'b0;
        unique case (state_q)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start) state_n = S_IMG_WR;
            end
            S_IMG_WR: begin
                state_n = S_POLL_RD;
                stage_n = STG_PRI;
            end
            S_POLL_RD: state_n = S_POLL_EVAL;
            S_POLL_EVAL: begin
                unique case (verdict)
                    VERD_PASS: begin
                        unique case (stage_q)
                            STG_PRI: begin
                                state_n = S_POLL_RD;
                                stage_n = STG_LDR;
                            end
                            STG_LDR:  state_n = S_LEN_CLR;
                            STG_META: state_n = S_SEG_WAIT;
                            STG_AUTH: state_n = S_DONE;
                        endcase
                    end
                    VERD_FAIL: state_n = S_FAIL;
                    default:   state_n = S_POLL_WAIT;
                endcase
            end
            S_POLL_WAIT: begin
                if (tick_ms) begin
                    if (at_last) begin
                        state_n    = S_FAIL;
                        fail_tmo_n = 1'b1;
                    end else begin
                        state_n = S_POLL_RD;
                    end
                end
            end
            S_LEN_CLR:  state_n = S_META_WR;
            S_META_WR:  state_n = S_META_CMD;
            S_META_CMD: begin
                state_n = S_POLL_RD;
                stage_n = STG_META;
            end
            S_SEG_WAIT: begin
                if (seg_valid) begin
                    if (!skip) begin
                        state_n = S_LEN_RD;
                    end else if (seg_last) begin
                        state_n = S_POLL_RD;
                        stage_n = STG_AUTH;
                    end
                end
            end
            S_LEN_RD:   state_n = S_LEN_EVAL;
            S_LEN_EVAL: state_n = (mb_rdata == '0) ? S_BASE_WR : S_LEN_WR;
            S_BASE_WR:  state_n = S_LOAD_CMD;
            S_LOAD_CMD: state_n = S_LEN_WR;
            S_LEN_WR: begin
                if (last_q) begin
                    state_n = S_POLL_RD;
                    stage_n = STG_AUTH;
                end else begin
                    state_n = S_SEG_WAIT;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            stage_q <= STG_PRI;
        end else begin
            state_q <= state_n;
            stage_q <= stage_n;
        end
    end

    // ---------------- datapath and result flags ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q    <= '0;
            size_q   <= '0;
            last_q   <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
            tmo      <= 1'b0;
            err_code <= '0;
        end else begin
            if (state_q == S_SEG_WAIT && seg_valid && !skip) begin
                size_q <= seg_size;
                last_q <= seg_last;
            end
            if (state_q == S_LEN_EVAL) len_q <= mb_rdata;

            if (idle_like && start) begin
                done     <= 1'b0;
                err      <= 1'b0;
                tmo      <= 1'b0;
                err_code <= '0;
            end else if (state_n == S_DONE && state_q != S_DONE) begin
                done <= 1'b1;
            end else if (state_n == S_FAIL && state_q != S_FAIL) begin
                err      <= !fail_tmo_n;
                tmo      <= fail_tmo_n;
                err_code <= {stage_q, fail_tmo_n};
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        mb_wr     = 1'b0;
        mb_rd     = 1'b0;
        mb_addr   = OFS_IMG;
        mb_wdata  = '0;
        seg_ready = 1'b0;
        unique case (state_q)
            S_IMG_WR: begin
                mb_wr    = 1'b1;
                mb_addr  = OFS_IMG;
                mb_wdata = img_addr;
            end
            S_POLL_RD: begin
                mb_rd   = 1'b1;
                mb_addr = (stage_q == STG_PRI) ? OFS_PRI : OFS_LDR;
            end
            S_LEN_CLR: begin
                mb_wr   = 1'b1;
                mb_addr = OFS_LEN;
            end
            S_META_WR: begin
                mb_wr    = 1'b1;
                mb_addr  = OFS_META;
                mb_wdata = meta_addr;
            end
            S_META_CMD: begin
                mb_wr    = 1'b1;
                mb_addr  = OFS_CMD;
                mb_wdata = DW'(CMD_META_RDY);
            end
            S_SEG_WAIT: seg_ready = 1'b1;
            S_LEN_RD: begin
                mb_rd   = 1'b1;
                mb_addr = OFS_LEN;
            end
            S_BASE_WR: begin
                mb_wr    = 1'b1;
                mb_addr  = OFS_START;
                mb_wdata = code_base;
            end
            S_LOAD_CMD: begin
                mb_wr    = 1'b1;
                mb_addr  = OFS_CMD;
                mb_wdata = DW'(CMD_LOAD_RDY);
            end
            S_LEN_WR: begin
                mb_wr    = 1'b1;
                mb_addr  = OFS_LEN;
                mb_wdata = len_q + size_q;
            end
            default: ;
        endcase
    end

    // ---------------- assertions ----------------
    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idle_like |-> (!mb_wr && !mb_rd && !seg_ready));

    assert_neg_never_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_POLL_EVAL && stage_q != STG_PRI && mb_rdata[DW-1]) |=> (state_q == S_FAIL));

    assert_load_after_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_wr && mb_addr == OFS_CMD && mb_wdata == DW'(CMD_LOAD_RDY))
        |-> $past(mb_wr && mb_addr == OFS_START));

    assert_tmo_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo) |-> $past(tick_ms));

    assert_one_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err, tmo}));

    assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((done || err || tmo) && !start) |=> $stable({done, err, tmo, err_code}));

endmodule

// File: tb/boot_auth_seq_tb_top.sv
module boot_auth_seq_tb_top;

    localparam int DW = 32;
    localparam int PL = 6;
    localparam int LL = 8;
    localparam int ML = 6;
    localparam int AL = 10;
    localparam int NEVER = 1000000;

    localparam logic [31:0] IMG  = 32'h8600_0000;
    localparam logic [31:0] META = 32'h9100_0000;
    localparam logic [31:0] BASE = 32'h8800_0000;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tick_ms = 1'b0;
    logic seg_valid = 1'b0, seg_loadable = 1'b0, seg_hash = 1'b0, seg_last = 1'b0;
    logic [DW-1:0] seg_size = '0;
    logic seg_ready, mb_wr, mb_rd, done, err, tmo;
    logic [4:0] mb_addr;
    logic [DW-1:0] mb_wdata;
    logic [DW-1:0] mb_rdata = '0;
    logic [2:0] err_code;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    boot_auth_seq #(.DW(DW), .PRI_LIMIT(PL), .LDR_LIMIT(LL),
                    .META_LIMIT(ML), .AUTH_LIMIT(AL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tick_ms(tick_ms),
        .img_addr(IMG), .meta_addr(META), .code_base(BASE),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_loadable(seg_loadable),
        .seg_hash(seg_hash), .seg_size(seg_size), .seg_last(seg_last),
        .mb_wr(mb_wr), .mb_rd(mb_rd), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
        .mb_rdata(mb_rdata), .done(done), .err(err), .tmo(tmo), .err_code(err_code)
    );

    // tick every 4 cycles
    int tick_div = 0;
    always @(posedge clk) begin
        tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
        tick_ms  <= (tick_div == 3);
    end

    // ---------------- remote mailbox model ----------------
    int pri_hold, ldr_hold, meta_hold, auth_hold;
    logic [31:0] pri_val, ldr_val, meta_pre, meta_val, auth_pre, auth_val;
    logic model_clr = 1'b0, auth_go = 1'b0;
    logic [31:0] len_reg = '0;
    int phase = 0, ph_rd = 0, rd_pri = 0, rd_sts = 0, rd_len = 0, wr_n = 0;
    logic [4:0]  wa [0:31];
    logic [31:0] wd [0:31];

    always @(posedge clk) begin
        if (model_clr) begin
            phase <= 0; ph_rd <= 0; rd_pri <= 0; rd_sts <= 0; rd_len <= 0; wr_n <= 0;
        end else begin
            if (auth_go && phase != 2) begin
                phase <= 2; ph_rd <= 0;
            end
            if (mb_rd) begin
                case (mb_addr)
                    5'h04: begin
                        mb_rdata <= (rd_pri < pri_hold) ? 32'd0 : pri_val;
                        rd_pri   <= rd_pri + 1;
                    end
                    5'h0C: begin
                        if (phase == 0)      mb_rdata <= (ph_rd < ldr_hold) ? 32'd0 : ldr_val;
                        else if (phase == 1) mb_rdata <= (ph_rd < meta_hold) ? meta_pre : meta_val;
                        else                 mb_rdata <= (ph_rd < auth_hold) ? auth_pre : auth_val;
                        ph_rd  <= ph_rd + 1;
                        rd_sts <= rd_sts + 1;
                    end
                    5'h18: begin
                        mb_rdata <= len_reg;
                        rd_len   <= rd_len + 1;
                    end
                    default: mb_rdata <= 32'hDEAD_BEEF;
                endcase
            end
            if (mb_wr) begin
                if (wr_n < 32) begin
                    wa[wr_n] <= mb_addr;
                    wd[wr_n] <= mb_wdata;
                end
                wr_n <= wr_n + 1;
                if (mb_addr == 5'h18) len_reg <= mb_wdata;
                if (mb_addr == 5'h08 && mb_wdata == 32'd1) begin
                    phase <= 1; ph_rd <= 0;
                end
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        @(negedge clk); model_clr = 1'b1; auth_go = 1'b0;
        @(negedge clk); model_clr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_end();
        int k;
        for (k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (done || err || tmo) break;
        end
        if (k >= 4000) chk(1'b0, "watchdog", 32'(k), 32'd4000);
    endtask

    task automatic send_seg(input bit ld, input bit hs, input logic [31:0] sz, input bit lst);
        int k;
        @(negedge clk);
        seg_valid = 1'b1; seg_loadable = ld; seg_hash = hs; seg_size = sz; seg_last = lst;
        for (k = 0; k < 4000 && !seg_ready; k++) @(negedge clk);
        @(negedge clk);
        seg_valid = 1'b0;
    endtask

    task automatic cfg_pass();
        pri_hold = 0;  pri_val = 32'd1;
        ldr_hold = 0;  ldr_val = 32'd1;
        meta_hold = 0; meta_pre = 32'd0; meta_val = 32'd3;
        auth_hold = 0; auth_pre = 32'd0; auth_val = 32'd4;
    endtask

    task automatic chk_wr(input int i, input logic [4:0] a, input logic [31:0] d, input string req);
        chk(wa[i] == a, req, 32'(wa[i]), 32'(a));
        chk(wd[i] == d, req, wd[i], d);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk({done, err, tmo} == 3'b000, "R1 flags", 32'({done, err, tmo}), 32'd0);
        chk({mb_wr, mb_rd, seg_ready} == 3'b000, "R1 bus", 32'({mb_wr, mb_rd, seg_ready}), 32'd0);
    endtask

    task automatic t_full_boot();
        cfg_pass();
        pri_hold = 2;
        ldr_hold = 1;  ldr_val = 32'd2;
        meta_hold = 2; meta_pre = 32'd1;
        auth_hold = 3; auth_pre = 32'd3;
        clear_model();
        pulse_start();
        send_seg(1'b1, 1'b0, 32'h100, 1'b0);
        send_seg(1'b1, 1'b1, 32'h200, 1'b0);
        send_seg(1'b1, 1'b0, 32'h0,   1'b0);
        send_seg(1'b0, 1'b0, 32'h300, 1'b0);
        chk(wr_n == 7, "R8 skip writes", 32'(wr_n), 32'd7);
        chk(rd_len == 1, "R8 skip reads", 32'(rd_len), 32'd1);
        send_seg(1'b1, 1'b0, 32'h40, 1'b1);
        auth_go = 1'b1;
        wait_end();
        chk(done == 1'b1 && err == 1'b0 && tmo == 1'b0, "R9 done", 32'({done, err, tmo}), 32'b100);
        chk(wr_n == 8, "R7 write count", 32'(wr_n), 32'd8);
        chk_wr(0, 5'h00, IMG, "R2 image write");
        chk_wr(1, 5'h18, 32'h0, "R5 length clear");
        chk_wr(2, 5'h10, META, "R5 meta addr");
        chk_wr(3, 5'h08, 32'd1, "R5 meta cmd");
        chk_wr(4, 5'h14, BASE, "R7 code base");
        chk_wr(5, 5'h08, 32'd2, "R7 load cmd");
        chk_wr(6, 5'h18, 32'h100, "R7 first length");
        chk_wr(7, 5'h18, 32'h140, "R7 accumulated length");
        chk(rd_pri == 3, "R3 primary polls", 32'(rd_pri), 32'd3);
        chk(rd_len == 2, "R8 length reads", 32'(rd_len), 32'd2);
        chk(rd_sts == 2 + 3 + 4, "R6 status polls", 32'(rd_sts), 32'd9);
    endtask

    task automatic t_pri_bad();
        cfg_pass(); pri_val = 32'd5;
        clear_model(); pulse_start(); wait_end();
        chk(err == 1'b1 && err_code == 3'b000, "R3 bad primary", 32'({err, err_code}), 32'b1000);
        chk(wr_n == 1, "R3 no further writes", 32'(wr_n), 32'd1);
    endtask

    task automatic t_ldr_bad(input logic [31:0] v);
        cfg_pass(); ldr_val = v;
        clear_model(); pulse_start(); wait_end();
        chk(err == 1'b1 && err_code == 3'b010, "R4 bad loader", 32'({err, err_code}), 32'b1010);
    endtask

    task automatic t_meta_neg();
        cfg_pass(); meta_hold = 1; meta_pre = 32'd2; meta_val = 32'hFFFF_FFF0;
        clear_model(); pulse_start(); wait_end();
        chk(err == 1'b1 && err_code == 3'b100, "R6 meta negative", 32'({err, err_code}), 32'b1100);
        chk(rd_sts == 3, "R6 meta polls", 32'(rd_sts), 32'd3);
    endtask

    task automatic t_auth_neg();
        cfg_pass(); auth_val = 32'h8000_0000;
        clear_model(); pulse_start();
        send_seg(1'b1, 1'b0, 32'h10, 1'b1);
        auth_go = 1'b1;
        wait_end();
        chk(err == 1'b1 && err_code == 3'b110, "R6 auth negative", 32'({err, err_code}), 32'b1110);
    endtask

    task automatic t_pri_timeout();
        cfg_pass(); pri_hold = NEVER;
        clear_model(); pulse_start(); wait_end();
        chk(tmo == 1'b1 && err == 1'b0 && err_code == 3'b001, "R10 primary timeout",
            32'({tmo, err, err_code}), 32'b10001);
        chk(rd_pri == PL, "R10 primary reads", 32'(rd_pri), 32'(PL));
    endtask

    task automatic t_limit_edge();
        cfg_pass(); pri_hold = PL - 1; ldr_hold = NEVER;
        clear_model(); pulse_start(); wait_end();
        chk(rd_pri == PL, "R11 pass on last read", 32'(rd_pri), 32'(PL));
        chk(tmo == 1'b1 && err_code == 3'b011, "R10 loader timeout", 32'({tmo, err_code}), 32'b1011);
        chk(rd_sts == LL, "R10 loader reads", 32'(rd_sts), 32'(LL));
    endtask

    task automatic t_auth_timeout();
        cfg_pass(); auth_hold = NEVER;
        clear_model(); pulse_start();
        send_seg(1'b0, 1'b0, 32'h10, 1'b1);
        auth_go = 1'b1;
        wait_end();
        chk(tmo == 1'b1 && err_code == 3'b111, "R10 auth timeout", 32'({tmo, err_code}), 32'b1111);
        chk(wr_n == 4, "R8 skipped last segment", 32'(wr_n), 32'd4);
    endtask

    task automatic t_restart();
        cfg_pass();
        clear_model(); pulse_start();
        for (int k = 0; k < 2000 && !seg_ready; k++) @(negedge clk);
        pulse_start();
        repeat (3) @(negedge clk);
        chk(wr_n == 4, "R12 start while busy", 32'(wr_n), 32'd4);
        send_seg(1'b1, 1'b0, 32'h20, 1'b1);
        auth_go = 1'b1;
        wait_end();
        chk(done == 1'b1, "R12 run completes", 32'(done), 32'd1);
        repeat (30) @(negedge clk);
        chk(done == 1'b1 && err == 1'b0, "R12 flag holds", 32'({done, err}), 32'b10);
        clear_model(); pri_val = 32'd7;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b0, "R12 restart clears", 32'(done), 32'd0);
        wait_end();
        chk(err == 1'b1 && err_code == 3'b000, "R12 second run", 32'({err, err_code}), 32'b1000);
    endtask

    // ---------------- sequence ----------------
    initial begin
        cfg_pass();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_full_boot();
        t_pri_bad();
        t_ldr_bad(32'd3);
        t_ldr_bad(32'h8000_0001);
        t_meta_neg();
        t_auth_neg();
        t_pri_timeout();
        t_limit_edge();
        t_auth_timeout();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule